// File: doc/BRIEF.md
# PCI-Bound DMA Transfer Shape Guard

This block sits beside a DMA engine whose transfers may target a PCI bus interface. Each time the engine presents a transfer request, the guard inspects its shape in the cycle of the start strobe. The shape covers:

- whether it is a burst,
- the burst length in double words,
- the signed address step,
- whether it uses dual or single addressing,
- the source address, destination address and byte count,
- whether an external I/O device takes part.

From that check the guard decides whether the bus interface could carry the transfer. Shapes the interface cannot carry are blocked and recorded in sticky status bits, one bit per kind of violation. One unsupported combination is a single-address transfer involving an external I/O device. That transfer is quietly dropped: it is blocked, but no status is recorded.

Software or a controller clears status bits by writing ones to them. A one-cycle error pulse marks any request that sets a status bit which was previously clear. The pulse suits an interrupt line that should fire once per new fault, not once per repeated fault.

Top module: `pci_dma_guard`

## Requirements
- R1: After reset, `status_o` is 0000, and `blocked_o` and `err_pulse_o` are 0.
- R2: A burst request (`burst_i`=1) with `burst_dw_i` greater than 8 sets `status_o[0]`. A length of exactly 8 does not set it.
- R3: A burst request whose `step_i` equals -8 sets `status_o[1]`. Other negative steps, such as -4, do not set it.
- R4: A burst request whose `step_i` equals 0 sets `status_o[2]`.
- R5: A dual-address (`dual_i`=1) burst request sets `status_o[3]` when the low three bits of `src_i`, `dst_i` or `count_i` are non-zero. A single-address burst never sets `status_o[3]`.
- R6: A request with `dual_i`=0 and `ext_io_i`=1 is suppressed. It drives `blocked_o`, leaves `status_o` unchanged whatever its other fields hold, and gives no `err_pulse_o`.
- R7: A non-burst request (`burst_i`=0) sets no status bit, whatever its length, step or alignment.
- R8: When several conditions hold for one request, all matching status bits set in the same cycle.
- R9: Status bits are sticky. With `clr_we_i`=1, each 1 in `clr_data_i` clears the matching bit, and each 0 leaves it unchanged. A set and a clear of the same bit in the same cycle leave the bit set.
- R10: `blocked_o` is 1 for exactly the one cycle after a start strobe whose request is flagged or suppressed. A clean request leaves it 0.
- R11: `err_pulse_o` is 1 for the one cycle after a start strobe only if that request sets a status bit that was 0 before the edge. A repeat of an already-recorded fault gives `blocked_o` without a pulse.
- R12: All outputs are registered. The effect of a request sampled on one rising edge appears right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transfer request strobe |
| burst_i | input | 1 | Request is a burst |
| burst_dw_i | input | 6 | Burst length in double words |
| step_i | input | 8 | Signed address step in bytes |
| dual_i | input | 1 | 1 = dual address, 0 = single address |
| ext_io_i | input | 1 | External I/O device takes part |
| src_i | input | 32 | Source address |
| dst_i | input | 32 | Destination address |
| count_i | input | 24 | Byte count |
| clr_we_i | input | 1 | Status clear strobe |
| clr_data_i | input | 4 | Write-one-to-clear mask |
| status_o | output | 4 | Sticky status: [0] too long, [1] step -8, [2] step 0, [3] misaligned |
| blocked_o | output | 1 | Request was blocked |
| err_pulse_o | output | 1 | A status bit was newly set |

## Verification
A corrupted status register would show as a wrong `status_o` right after the edge. It would also distort the next request's `err_pulse_o`: a lost bit causes a spurious pulse on the repeat request, and a stuck bit hides the pulse. A wrong decode shows on `blocked_o` one cycle after the strobe. The bench therefore repeats the same faults, clears the bits with mixed masks, and runs clears at the same time as sets. This lets a wrong state show up within a cycle or two.

// File: rtl/pci_dma_guard.sv
module pci_dma_guard #(
  parameter int ADDR_W       = 32,
  parameter int CNT_W        = 24,
  parameter int LEN_W        = 6,
  parameter int STEP_W       = 8,
  parameter int MAX_BURST_DW = 8,
  parameter int DW_BYTES     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     burst_i,
  input  logic [LEN_W-1:0]         burst_dw_i,
  input  logic signed [STEP_W-1:0] step_i,
  input  logic                     dual_i,
  input  logic                     ext_io_i,
  input  logic [ADDR_W-1:0]        src_i,
  input  logic [ADDR_W-1:0]        dst_i,
  input  logic [CNT_W-1:0]         count_i,
  input  logic                     clr_we_i,
  input  logic [3:0]               clr_data_i,
  output logic [3:0]               status_o,
  output logic                     blocked_o,
  output logic                     err_pulse_o
);
  localparam int AL_W = $clog2(DW_BYTES);
  localparam logic signed [STEP_W-1:0] NEG_STEP = STEP_W'(-DW_BYTES);
  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_BURST_DW);

  logic       suppress, checked;
  logic [3:0] hit, clr_mask, fresh, status_q;

  assign suppress = start_i & ~dual_i & ext_io_i;
  assign checked  = start_i & burst_i & ~suppress;

  assign hit[0] = checked & (burst_dw_i > LEN_LIMIT);
  assign hit[1] = checked & (step_i == NEG_STEP);
  assign hit[2] = checked & (step_i == '0);
  assign hit[3] = checked & dual_i &
                  ((|src_i[AL_W-1:0]) | (|dst_i[AL_W-1:0]) | (|count_i[AL_W-1:0]));

  assign clr_mask = clr_we_i ? clr_data_i : 4'b0000;
  assign fresh    = hit & ~status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q    <= '0;
      blocked_o   <= 1'b0;
      err_pulse_o <= 1'b0;
    end else begin
      status_q    <= (status_q & ~clr_mask) | hit;
      blocked_o   <= (|hit) | suppress;
      err_pulse_o <= |fresh;
    end
  end

  assign status_o = status_q;

  // R9: a bit only drops after a clear of that bit
  for (genvar b = 0; b < 4; b++) begin : g_sticky
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status_o[b]) && !($past(clr_we_i) && $past(clr_data_i[b]))) |-> status_o[b])
      else $error("status bit %0d dropped without clear", b);
  end

  p_blocked_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_o |-> $past(start_i))
    else $error("blocked without a start");

  p_pulse_needs_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_o |-> blocked_o)
    else $error("error pulse without block");

  p_pulse_new_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_o |-> ((status_o & ~$past(status_o)) != 4'b0000 || $past(clr_we_i)))
    else $error("error pulse with no newly set bit");

  p_suppress_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_i && !dual_i && ext_io_i) |-> (blocked_o && !err_pulse_o &&
      ((status_o & ~$past(status_o)) == 4'b0000)))
    else $error("suppressed request changed status");

  p_plain_exempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_i && !burst_i) |-> (!err_pulse_o &&
      ((status_o & ~$past(status_o)) == 4'b0000)))
    else $error("non-burst request set status");
endmodule

// File: tb/test_pci_dma_guard.sv
`timescale 1ns/1ps
module test_pci_dma_guard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, burst_i = 0, dual_i = 0, ext_io_i = 0, clr_we_i = 0;
  logic [5:0] burst_dw_i = '0;
  logic signed [7:0] step_i = '0;
  logic [31:0] src_i = '0, dst_i = '0;
  logic [23:0] count_i = '0;
  logic [3:0] clr_data_i = '0;
  logic [3:0] status_o;
  logic blocked_o, err_pulse_o;

  always #2 clk = ~clk;

  pci_dma_guard i_pci_dma_guard (
    .clk, .rst_n, .start_i, .burst_i, .burst_dw_i, .step_i, .dual_i,
    .ext_io_i, .src_i, .dst_i, .count_i, .clr_we_i, .clr_data_i,
    .status_o, .blocked_o, .err_pulse_o);

  typedef struct {
    int unsigned stamp;
    logic [3:0]  st;
    logic        blk;
    logic        pls;
    string       tag;
  } exp_t;

  exp_t q[$];
  int unsigned cyc = 0;
  int errors = 0, checks = 0;
  logic [3:0] model = 4'b0000;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got {st,blk,pls}=%b expected %b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() != 0 && q[0].stamp < cyc) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, {status_o, blocked_o, err_pulse_o}, {e.st, e.blk, e.pls});
    end
  end

  task automatic drive(string tag, logic st, logic bu, logic [5:0] len,
                       logic signed [7:0] stp, logic du, logic ex,
                       logic [31:0] s, logic [31:0] d, logic [23:0] c,
                       logic cw, logic [3:0] cd);
    logic [3:0] h;
    logic sup;
    exp_t e;
    @(negedge clk);
    start_i = st; burst_i = bu; burst_dw_i = len; step_i = stp; dual_i = du;
    ext_io_i = ex; src_i = s; dst_i = d; count_i = c; clr_we_i = cw; clr_data_i = cd;
    sup = st && !du && ex;
    h = 4'b0000;
    if (st && bu && !sup) begin
      h[0] = (len > 8);
      h[1] = (stp == -8);
      h[2] = (stp == 0);
      h[3] = du && ((s[2:0] != 0) || (d[2:0] != 0) || (c[2:0] != 0));
    end
    e.stamp = cyc;
    e.pls = |(h & ~model);
    e.blk = (|h) || sup;
    model = (model & ~(cw ? cd : 4'b0000)) | h;
    e.st = model;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    start_i = 0; clr_we_i = 0; clr_data_i = '0;
  endtask

  task automatic req(string tag, logic bu, logic [5:0] len, logic signed [7:0] stp,
                     logic du, logic ex, logic [31:0] s, logic [31:0] d, logic [23:0] c);
    drive(tag, 1'b1, bu, len, stp, du, ex, s, d, c, 1'b0, 4'b0000);
  endtask

  task automatic clear(string tag, logic [3:0] m);
    drive(tag, 1'b0, 1'b0, 6'd0, 8'sd8, 1'b1, 1'b0, 32'h0, 32'h0, 24'h0, 1'b1, m);
  endtask

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {status_o, blocked_o, err_pulse_o}, 6'b000000);
    rst_n = 1'b1;
    req("R2 len 8 clean R10", 1, 6'd8, 8'sd8, 1, 0, 32'h100, 32'h200, 24'h40);
    req("R2 len 9 R12", 1, 6'd9, 8'sd8, 1, 0, 32'h100, 32'h200, 24'h40);
    req("R11 repeat no pulse", 1, 6'd9, 8'sd8, 1, 0, 32'h100, 32'h200, 24'h40);
    clear("R9 zero mask", 4'b0000);
    clear("R9 clear bit0", 4'b0001);
    req("R3 step -8", 1, 6'd4, -8'sd8, 1, 0, 32'h100, 32'h200, 24'h40);
    req("R3 step -4 clean", 1, 6'd4, -8'sd4, 1, 0, 32'h100, 32'h200, 24'h40);
    req("R4 step 0", 1, 6'd4, 8'sd0, 1, 0, 32'h100, 32'h200, 24'h40);
    clear("R9 clear all", 4'b1111);
    req("R5 src misaligned", 1, 6'd2, 8'sd8, 1, 0, 32'h104, 32'h200, 24'h40);
    clear("R9 clear bit3", 4'b1000);
    req("R5 dst misaligned", 1, 6'd2, 8'sd8, 1, 0, 32'h100, 32'h201, 24'h40);
    clear("R9 clear bit3 b", 4'b1000);
    req("R5 count misaligned", 1, 6'd2, 8'sd8, 1, 0, 32'h100, 32'h200, 24'h43);
    clear("R9 clear bit3 c", 4'b1000);
    req("R5 single addr no align check", 1, 6'd2, 8'sd8, 0, 0, 32'h101, 32'h202, 24'h43);
    req("R6 suppressed", 1, 6'd20, 8'sd0, 0, 1, 32'h101, 32'h202, 24'h43);
    req("R6 ext dual still checked", 1, 6'd2, 8'sd0, 1, 1, 32'h100, 32'h200, 24'h40);
    clear("R9 clear bit2", 4'b0100);
    req("R7 non-burst exempt", 0, 6'd30, 8'sd0, 1, 0, 32'h101, 32'h202, 24'h43);
    req("R8 multi bits", 1, 6'd12, 8'sd0, 1, 0, 32'h100, 32'h205, 24'h40);
    drive("R9 set beats clear", 1, 1, 6'd12, 8'sd8, 1, 0, 32'h100, 32'h200, 24'h40, 1, 4'b0101);
    clear("R9 clear all end", 4'b1111);
    req("R10 clean after clear", 1, 6'd1, 8'sd8, 1, 0, 32'h0, 32'h8, 24'h8);
    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule